// File: doc/BRIEF.md
# Command/Response Buffer Control Registers

This block is the device-side register front end of a trusted-module command/response buffer interface. A host on a simple 32-bit memory-mapped bus takes ownership through a locality handshake. It moves the device between its idle and ready power states with request bits that clear themselves once acknowledged. It launches and cancels commands through dedicated start and cancel registers. Fixed buffer addresses and sizes are reported to the host for discovery.

Toward a command engine the block drives a one-cycle start pulse and a level cancel request. It takes back a done strobe and an error strobe. Reads are combinational and free of side effects. Writes take effect at the clock edge on which `wr_en` is high. The word index is `addr[6:2]`.

Top module: `cmd_resp_ctrl`

## Requirements
- R1: After reset, the locality state reads 0, the request word reads 0, the status word reads 0x2 (idle, no error), and start, cancel and `eng_start`/`eng_cancel` read 0.
- R2: Writing bit 0 of locality control (0x08) grants the locality. Locality state (0x00) then reads 0x82 (bit 1 assigned, bit 7 valid) and locality status (0x0C) reads 1. Writing bit 1 releases the locality, and release wins if both bits are written.
- R3: Writing bit 0 of the request word (0x40) leaves that bit reading 1 for exactly ACK_DLY cycles. It then clears, and status bit 1 (idle) reads 0.
- R4: Writing bit 1 of the request word leaves that bit reading 1 for ACK_DLY cycles. It then clears, and status bit 1 reads 1.
- R5: A ready request written while an idle request is pending replaces it. The idle bit never completes, and the device ends up ready.
- R6: A write of 1 to start bit 0 (0x4C) is accepted only if the locality is granted, the device is not idle and no command is running. On acceptance, start reads 1 and `eng_start` is high for exactly the following cycle. Otherwise the write has no effect.
- R7: While start reads 1, an `eng_done` strobe clears it at the next edge.
- R8: While start reads 1, an `eng_error` strobe clears start and sets status bit 0. That error bit stays set until the next accepted start.
- R9: Cancel bit 0 (0x48) takes the written value, reads back, and drives `eng_cancel` until the host writes it to 0.
- R10: The buffer words report fixed values: command size at 0x58, command address at 0x5C (low) and 0x60 (high), response size at 0x64, and response address at 0x68 and 0x6C. When the two addresses are equal, the response size reported equals the command size.
- R11: The 64-bit interface identifier reads at 0x30 (low) and 0x34 (high). Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| eng_start | output | 1 | One-cycle command launch pulse |
| eng_cancel | output | 1 | Cancel request level |
| eng_done | input | 1 | Engine completion strobe |
| eng_error | input | 1 | Engine error strobe |

## Verification
A corrupted pending counter shows up as a request bit that clears one cycle early or late, or as an idle bit that flips at the wrong edge. Either is visible on the read port within ACK_DLY+1 cycles of the request. A wrong start or error flag is visible on the next read of the start or status word. It also appears on `eng_start` in the cycle right after a start write that should or should not have been accepted. Because the bench compares every port each cycle against a behavioural model, each such divergence is reported on the cycle in which it first appears.

// File: rtl/cmd_resp_ctrl.sv
module cmd_resp_ctrl #(
  parameter int          ACK_DLY  = 3,
  parameter logic [63:0] IFACE_ID = 64'h0000_0001_0000_4014,
  parameter logic [63:0] CMD_ADDR = 64'h0000_0000_FED4_0080,
  parameter logic [63:0] RSP_ADDR = 64'h0000_0000_FED4_0080,
  parameter logic [31:0] CMD_SIZE = 32'h0000_0F80,
  parameter logic [31:0] RSP_SIZE = 32'h0000_0F80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [6:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        eng_start,
  output logic        eng_cancel,
  input  logic        eng_done,
  input  logic        eng_error
);
  localparam int          CW       = $clog2(ACK_DLY + 1);
  localparam logic [31:0] RSP_REPT = (CMD_ADDR == RSP_ADDR) ? CMD_SIZE : RSP_SIZE;

  logic [4:0]    widx;
  logic          gnt_q, idle_q, err_q, start_q, cancel_q, pend_rdy, pend_idl;
  logic [CW-1:0] cnt;
  logic          req_wr, accept;

  assign widx   = addr[6:2];
  assign req_wr = wr_en && widx == 5'd16 && (wdata[0] || wdata[1]);
  assign accept = wr_en && widx == 5'd19 && wdata[0] && gnt_q && !idle_q && !start_q;
  assign eng_cancel = cancel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (wr_en && widx == 5'd2) begin
        if (wdata[1])      gnt_q <= 1'b0;
        else if (wdata[0]) gnt_q <= 1'b1;
      end
      if (wr_en && widx == 5'd18) cancel_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_rdy <= 1'b0;
      pend_idl <= 1'b0;
      cnt      <= '0;
      idle_q   <= 1'b1;
    end else if (req_wr) begin
      pend_rdy <= wdata[0];
      pend_idl <= !wdata[0];
      cnt      <= CW'(ACK_DLY - 1);
    end else if (pend_rdy || pend_idl) begin
      if (cnt == '0) begin
        idle_q   <= pend_idl;
        pend_rdy <= 1'b0;
        pend_idl <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      err_q     <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= accept;
      if (accept) begin
        start_q <= 1'b1;
        err_q   <= 1'b0;
      end else if (start_q && eng_error) begin
        start_q <= 1'b0;
        err_q   <= 1'b1;
      end else if (start_q && eng_done) begin
        start_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (widx)
      5'd0:    rdata = gnt_q ? 32'h82 : 32'h0;
      5'd3:    rdata = {31'b0, gnt_q};
      5'd12:   rdata = IFACE_ID[31:0];
      5'd13:   rdata = IFACE_ID[63:32];
      5'd16:   rdata = {30'b0, pend_idl, pend_rdy};
      5'd17:   rdata = {30'b0, idle_q, err_q};
      5'd18:   rdata = {31'b0, cancel_q};
      5'd19:   rdata = {31'b0, start_q};
      5'd22:   rdata = CMD_SIZE;
      5'd23:   rdata = CMD_ADDR[31:0];
      5'd24:   rdata = CMD_ADDR[63:32];
      5'd25:   rdata = RSP_REPT;
      5'd26:   rdata = RSP_ADDR[31:0];
      5'd27:   rdata = RSP_ADDR[63:32];
      default: rdata = 32'h0;
    endcase
  end

  AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pend_rdy && pend_idl)); // R5
  AST_RDY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rdy && cnt == '0 && !req_wr |=> !idle_q && !pend_rdy); // R3
  AST_IDL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_idl && cnt == '0 && !req_wr |=> idle_q && !pend_idl); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && eng_done && !eng_error |=> !start_q); // R7
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && eng_error |=> err_q && !start_q); // R8
endmodule

// File: tb/sim_cmd_resp_ctrl.sv
module sim_cmd_resp_ctrl;
  localparam int          ACK = 3;
  localparam logic [63:0] IFID = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] BADDR = 64'h0000_0001_FED4_0080;
  localparam logic [31:0] CSZ = 32'h400;

  logic clk = 0, rst_n = 0, wr_en = 0, eng_done = 0, eng_error = 0;
  logic [6:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic eng_start, eng_cancel;
  int checks = 0, fails = 0, cyc_n = 0;
  bit finished = 0;

  int m_rdy, m_idl;
  bit m_gnt, m_idle, m_err, m_start, m_cancel, m_pulse;

  always #10 clk = ~clk;

  cmd_resp_ctrl #(.ACK_DLY(ACK), .IFACE_ID(IFID), .CMD_ADDR(BADDR), .RSP_ADDR(BADDR),
                  .CMD_SIZE(CSZ), .RSP_SIZE(32'h200)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_done(eng_done), .eng_error(eng_error));

  always @(posedge clk) begin
    cyc_n++;
    if (!rst_n) begin
      m_gnt = 0; m_idle = 1; m_err = 0; m_start = 0; m_cancel = 0; m_pulse = 0;
      m_rdy = 0; m_idl = 0;
    end else begin
      bit acc;
      acc = wr_en && addr[6:2] == 16 + 3 && wdata[0] && m_gnt && !m_idle && !m_start;
      m_pulse = acc;
      if (acc) begin m_start = 1; m_err = 0; end
      else if (m_start && eng_error) begin m_start = 0; m_err = 1; end
      else if (m_start && eng_done) m_start = 0;
      if (wr_en && addr[6:2] == 2) begin
        if (wdata[1]) m_gnt = 0; else if (wdata[0]) m_gnt = 1;
      end
      if (wr_en && addr[6:2] == 18) m_cancel = wdata[0];
      if (wr_en && addr[6:2] == 16 && (wdata[0] || wdata[1])) begin
        if (wdata[0]) begin m_rdy = ACK; m_idl = 0; end
        else begin m_idl = ACK; m_rdy = 0; end
      end else if (m_rdy > 0) begin
        m_rdy--; if (m_rdy == 0) m_idle = 0;
      end else if (m_idl > 0) begin
        m_idl--; if (m_idl == 0) m_idle = 1;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [6:0] a);
    case (a[6:2])
      0: return m_gnt ? 32'h82 : 0;
      3: return {31'b0, m_gnt};
      12: return IFID[31:0];
      13: return IFID[63:32];
      16: return {30'b0, m_idl > 0, m_rdy > 0};
      17: return {30'b0, m_idle, m_err};
      18: return {31'b0, m_cancel};
      19: return {31'b0, m_start};
      22: return CSZ;
      23: return BADDR[31:0];
      24: return BADDR[63:32];
      25: return CSZ;
      26: return BADDR[31:0];
      27: return BADDR[63:32];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(input logic w, input logic [6:0] a, input logic [31:0] d,
                     input logic dn, input logic er, input string tag);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; eng_done = dn; eng_error = er;
    #1;
    chk(tag, rdata, exp_rd(a));
    chk("R6 eng_start", {31'b0, eng_start}, {31'b0, m_pulse});
    chk("R9 eng_cancel", {31'b0, eng_cancel}, {31'b0, m_cancel});
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    cyc(0, a, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input string tag);
    cyc(1, a, d, 0, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    if (!finished) begin
      @(negedge clk); rst_n = 1;
    end
    // R1 reset state
    rd(7'h00, "R1 loc state"); rd(7'h40, "R1 request"); rd(7'h44, "R1 status");
    rd(7'h4C, "R1 start"); rd(7'h48, "R1 cancel");
    // R11 identifier and unmapped words
    rd(7'h30, "R11 id lo"); rd(7'h34, "R11 id hi"); rd(7'h38, "R11 ext"); rd(7'h10, "R11 reserved");
    // R10 buffer words, overlap gives equal sizes
    for (int i = 0; i < 6; i++) rd(7'h58 + 7'(4 * i), "R10 buffer info");
    // R6 start ignored with no grant and idle
    wr(7'h4C, 1, "R6 start no grant"); rd(7'h4C, "R6 start ignored");
    // R2 grant
    wr(7'h08, 1, "R2 request"); rd(7'h00, "R2 loc state"); rd(7'h0C, "R2 loc sts");
    // R6 start ignored while idle
    wr(7'h4C, 1, "R6 start idle"); rd(7'h4C, "R6 start ignored idle");
    // R4 idle request while already idle, then R5 ready overrides
    wr(7'h40, 2, "R4 idle req"); rd(7'h40, "R4 pending");
    wr(7'h40, 1, "R5 ready over idle");
    for (int i = 0; i < ACK + 2; i++) rd(i[0] ? 7'h44 : 7'h40, "R5 R3 ready progress");
    // R6 accepted start, R7 done
    wr(7'h4C, 1, "R6 start go"); rd(7'h4C, "R6 start running");
    wr(7'h4C, 1, "R6 start while running");
    rd(7'h4C, "R7 still running");
    cyc(0, 7'h4C, 0, 1, 0, "R7 done strobe"); rd(7'h4C, "R7 cleared");
    cyc(0, 7'h4C, 0, 1, 0, "R7 done when not running");
    // R8 error
    wr(7'h4C, 1, "R8 start"); cyc(0, 7'h44, 0, 0, 1, "R8 error strobe");
    rd(7'h44, "R8 error set"); rd(7'h4C, "R8 start cleared");
    rd(7'h44, "R8 error holds");
    wr(7'h4C, 1, "R8 restart"); rd(7'h44, "R8 error cleared");
    cyc(0, 7'h4C, 0, 1, 1, "R8 both strobes"); rd(7'h44, "R8 error wins");
    // R9 cancel
    wr(7'h48, 1, "R9 cancel set"); rd(7'h48, "R9 cancel reads");
    wr(7'h48, 0, "R9 cancel clear"); rd(7'h48, "R9 cancel cleared");
    // R4 idle request from ready, then start ignored
    wr(7'h40, 2, "R4 idle req");
    for (int i = 0; i < ACK + 2; i++) rd(i[0] ? 7'h44 : 7'h40, "R4 idle progress");
    wr(7'h4C, 1, "R6 start idle again"); rd(7'h4C, "R6 ignored");
    // R3 back to ready, R2 release (both bits) then start ignored
    wr(7'h40, 1, "R3 ready req");
    for (int i = 0; i < ACK + 1; i++) rd(7'h40, "R3 ready progress");
    wr(7'h08, 3, "R2 release wins"); rd(7'h00, "R2 released"); rd(7'h0C, "R2 sts released");
    wr(7'h4C, 1, "R6 start no grant"); rd(7'h4C, "R6 ignored no grant");
    rd(7'h44, "R3 status ready");
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule